// File: doc/BRIEF.md
# Shared-Pointer Indirect Register Window

This block gives a host a small I/O-mapped window onto two internal register banks. It does not map every register to its own address. The host first writes an index into a pointer port. Later accesses to one of two data ports then reach the entry at that index. One data port reaches the control-status bank and the other reaches the bus-configuration bank. Both data ports use the same pointer, so a single pointer write selects entry N in both banks at once.

An input pin picks between two layouts of the window. In word I/O layout the pointer port sits at offset 12h and the bus-configuration data port at 16h. In dword I/O layout they move to 14h and 1Ch. The control-status data port stays at 10h in both layouts. An access to any other offset is silently dropped.

The banks here are plain storage with no side effects. Their depth is a parameter. An index past the end of a bank reads as zero, and a write to such an index is thrown away. Reads complete one clock after the access is presented.

Top module: `ioport_window`

## Requirements
- R1: After reset the pointer is 0, every entry of both banks is 0, and `rd_valid` is low.
- R2: A write to the pointer port (offset 12h when `dword_mode`=0, 14h when `dword_mode`=1) loads `acc_wdata[7:0]` into the pointer. A read of that port returns the pointer in bits 7:0 and zero in bits 31:8, whatever was written to the upper bits.
- R3: Offset 10h, in either layout, reads or writes the control-status entry selected by the pointer.
- R4: The bus-configuration entry selected by the same pointer is reached at offset 16h when `dword_mode`=0 and at 1Ch when `dword_mode`=1. The two banks are separate storage, so a write to one never changes the other.
- R5: A read access at a decoded offset raises `rd_valid` with the result on `rd_data` in the cycle right after the access edge. `rd_valid` is low in every other cycle.
- R6: Data-port accesses leave the pointer unchanged. Only a pointer-port write changes it.
- R7: When the pointer is at or past the bank depth (default 32 control-status entries and 16 bus-configuration entries), a data-port read returns 0 and a write changes no entry. There is no wrap-around aliasing.
- R8: An access to an offset that is not decoded in the current layout changes no state and gives no `rd_valid`. This includes the other layout's pointer and bus-configuration offsets.
- R9: Bank entries are 16 bits wide. A data-port write stores `acc_wdata[15:0]`, and a data-port read returns the entry zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dword_mode | input | 1 | 0 selects the word I/O layout, 1 selects the dword I/O layout |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 5 | Byte offset of the access inside the window |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |

## Verification
The hardest situation to reach from the ports is the no-alias case. It needs a write through a pointer past the bank end, followed by a read of the in-range entry that a truncated index would have hit. That takes pointer loads to 40 and then 8 around the data writes. The other hard case is a layout switch in the middle of a run. The stimulus tries the other layout's offsets with a non-zero value and then reads back through the valid offsets, to show that the pointer and the banks kept their earlier contents.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PTR  = 2'd1,
      SEL_CSR  = 2'd2,
      SEL_BCR  = 2'd3
   } port_sel_e;

   localparam int OFF_CSR       = 'h10;
   localparam int OFF_PTR_WORD  = 'h12;
   localparam int OFF_PTR_DWORD = 'h14;
   localparam int OFF_BCR_WORD  = 'h16;
   localparam int OFF_BCR_DWORD = 'h1C;
endpackage

// File: rtl/iowin_decode.sv
module iowin_decode
   import iowin_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              dword_mode,
   input  logic [ADDR_W-1:0] addr,
   output port_sel_e         sel
);
   logic [ADDR_W-1:0] ptr_off;
   logic [ADDR_W-1:0] bcr_off;

   assign ptr_off = dword_mode ? ADDR_W'(OFF_PTR_DWORD) : ADDR_W'(OFF_PTR_WORD);
   assign bcr_off = dword_mode ? ADDR_W'(OFF_BCR_DWORD) : ADDR_W'(OFF_BCR_WORD);

   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(OFF_CSR))
         sel = SEL_CSR;
      else if (addr == ptr_off)
         sel = SEL_PTR;
      else if (addr == bcr_off)
         sel = SEL_BCR;
   end
endmodule

// File: rtl/iowin_ptr.sv
module iowin_ptr #(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] d,
   output logic [PTR_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end
endmodule

// File: rtl/iowin_bank.sv
module iowin_bank #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int AW = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic              in_range;
   logic [AW-1:0]     slot;

   assign slot = idx[AW-1:0];

   generate
      if (DEPTH == (1 << IDX_W)) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_partial
         assign in_range = ({1'b0, idx} < (IDX_W+1)'(DEPTH));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= '0;
      end else if (we && in_range) begin
         mem[slot] <= wdata;
      end
   end

   assign rdata = in_range ? mem[slot] : '0;
endmodule

// File: rtl/ioport_window.sv
module ioport_window
   import iowin_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int BUS_W     = 32,
   parameter int PTR_W     = 8,
   parameter int REG_W     = 16,
   parameter int CSR_DEPTH = 32,
   parameter int BCR_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dword_mode,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [BUS_W-1:0]  acc_wdata,
   output logic              rd_valid,
   output logic [BUS_W-1:0]  rd_data
);
   generate
      if (ADDR_W < 5)
         $error("ioport_window: ADDR_W must cover offset 1Ch");
      if (BUS_W <= REG_W || BUS_W <= PTR_W)
         $error("ioport_window: BUS_W must exceed REG_W and PTR_W");
      if (CSR_DEPTH < 2 || CSR_DEPTH > (1 << PTR_W))
         $error("ioport_window: CSR_DEPTH out of range");
      if (BCR_DEPTH < 2 || BCR_DEPTH > (1 << PTR_W))
         $error("ioport_window: BCR_DEPTH out of range");
   endgenerate

   port_sel_e        sel;
   logic [PTR_W-1:0] ptr_q;
   logic [REG_W-1:0] csr_rd;
   logic [REG_W-1:0] bcr_rd;
   logic             wr_acc;
   logic             rd_acc;
   logic [BUS_W-1:0] rd_mux;
   logic             unused_wbits;

   assign unused_wbits = ^acc_wdata[BUS_W-1:REG_W];
   assign wr_acc = acc_valid &&  acc_write;
   assign rd_acc = acc_valid && !acc_write && (sel != SEL_NONE);

   iowin_decode #(.ADDR_W(ADDR_W)) u_dec (
      .dword_mode (dword_mode),
      .addr       (acc_addr),
      .sel        (sel)
   );

   iowin_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_acc && sel == SEL_PTR),
      .d     (acc_wdata[PTR_W-1:0]),
      .q     (ptr_q)
   );

   iowin_bank #(.DEPTH(CSR_DEPTH), .DATA_W(REG_W), .IDX_W(PTR_W)) u_csr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_acc && sel == SEL_CSR),
      .idx   (ptr_q),
      .wdata (acc_wdata[REG_W-1:0]),
      .rdata (csr_rd)
   );

   iowin_bank #(.DEPTH(BCR_DEPTH), .DATA_W(REG_W), .IDX_W(PTR_W)) u_bcr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_acc && sel == SEL_BCR),
      .idx   (ptr_q),
      .wdata (acc_wdata[REG_W-1:0]),
      .rdata (bcr_rd)
   );

   always_comb begin
      case (sel)
         SEL_PTR: rd_mux = {{(BUS_W-PTR_W){1'b0}}, ptr_q};
         SEL_CSR: rd_mux = {{(BUS_W-REG_W){1'b0}}, csr_rd};
         SEL_BCR: rd_mux = {{(BUS_W-REG_W){1'b0}}, bcr_rd};
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_acc;
         if (rd_acc)
            rd_data <= rd_mux;
      end
   end
endmodule

// File: rtl/iowin_chk.sv
module iowin_chk
   import iowin_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int BUS_W     = 32,
   parameter int PTR_W     = 8,
   parameter int REG_W     = 16,
   parameter int CSR_DEPTH = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dword_mode,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [BUS_W-1:0]  acc_wdata,
   input logic              rd_valid,
   input logic [BUS_W-1:0]  rd_data,
   input logic [PTR_W-1:0]  ptr_q
);
   logic at_ptr, at_csr, at_bcr, ptr_wr, ptr_rd, csr_rd_oor, undec;

   assign at_ptr = acc_addr == (dword_mode ? ADDR_W'(OFF_PTR_DWORD) : ADDR_W'(OFF_PTR_WORD));
   assign at_bcr = acc_addr == (dword_mode ? ADDR_W'(OFF_BCR_DWORD) : ADDR_W'(OFF_BCR_WORD));
   assign at_csr = acc_addr == ADDR_W'(OFF_CSR);
   assign ptr_wr = acc_valid && acc_write && at_ptr;
   assign ptr_rd = acc_valid && !acc_write && at_ptr;
   assign undec  = acc_valid && !at_ptr && !at_csr && !at_bcr;
   assign csr_rd_oor = acc_valid && !acc_write && at_csr &&
                       ({1'b0, ptr_q} >= (PTR_W+1)'(CSR_DEPTH));

   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr |=> ptr_q == $past(acc_wdata[PTR_W-1:0]));                      // R2
   AST_PTR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_rd |=> rd_valid && rd_data == {{(BUS_W-PTR_W){1'b0}}, $past(ptr_q)}); // R2
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_wr |=> $stable(ptr_q));                                           // R6
   AST_RDV_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(acc_valid && !acc_write));                          // R5
   AST_UNDECODED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      undec |=> !rd_valid);                                                  // R8
   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rd_oor |=> rd_valid && rd_data == '0);                             // R7
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_data[BUS_W-1:REG_W] == '0);                            // R9
endmodule

bind ioport_window iowin_chk #(
   .ADDR_W(ADDR_W), .BUS_W(BUS_W), .PTR_W(PTR_W), .REG_W(REG_W), .CSR_DEPTH(CSR_DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dword_mode (dword_mode),
   .acc_valid  (acc_valid),
   .acc_write  (acc_write),
   .acc_addr   (acc_addr),
   .acc_wdata  (acc_wdata),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data),
   .ptr_q      (ptr_q)
);

// File: tb/ioport_window_test.sv
`timescale 1ns/1ps
module ioport_window_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dword_mode = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [4:0]  acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ioport_window uut (
      .clk(clk), .rst_n(rst_n), .dword_mode(dword_mode),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // {mode, write, addr[4:0], wdata[31:0], exp_valid, exp_data[31:0], req[3:0]}
   localparam int NV = 31;
   localparam logic [75:0] VEC [NV] = '{
      {1'b0,1'b1,5'h12,32'hFFFF_FF05,1'b0,32'h0,4'd2},         // R2 pointer = 5
      {1'b0,1'b0,5'h12,32'h0,1'b1,32'h0000_0005,4'd2},         // R2 upper bits zero
      {1'b0,1'b1,5'h10,32'h1234_A1B2,1'b0,32'h0,4'd3},         // R3 CSR5 write
      {1'b0,1'b0,5'h10,32'h0,1'b1,32'h0000_A1B2,4'd9},         // R9 zero-extended
      {1'b0,1'b0,5'h16,32'h0,1'b1,32'h0,4'd4},                 // R4 BCR5 untouched
      {1'b0,1'b1,5'h16,32'h0000_C3D4,1'b0,32'h0,4'd4},         // R4 BCR5 write
      {1'b0,1'b0,5'h16,32'h0,1'b1,32'h0000_C3D4,4'd4},         // R4
      {1'b0,1'b0,5'h10,32'h0,1'b1,32'h0000_A1B2,4'd4},         // R4 banks separate
      {1'b0,1'b0,5'h12,32'h0,1'b1,32'h0000_0005,4'd6},         // R6 pointer kept
      {1'b1,1'b0,5'h14,32'h0,1'b1,32'h0000_0005,4'd2},         // R2 dword pointer port
      {1'b1,1'b0,5'h10,32'h0,1'b1,32'h0000_A1B2,4'd3},         // R3 dword CSR port
      {1'b1,1'b0,5'h1C,32'h0,1'b1,32'h0000_C3D4,4'd4},         // R4 dword BCR port
      {1'b1,1'b1,5'h12,32'h0000_0009,1'b0,32'h0,4'd8},         // R8 word ptr offset in dword
      {1'b1,1'b0,5'h14,32'h0,1'b1,32'h0000_0005,4'd8},         // R8
      {1'b1,1'b1,5'h16,32'h0000_7777,1'b0,32'h0,4'd8},         // R8 word BCR offset in dword
      {1'b1,1'b0,5'h1C,32'h0,1'b1,32'h0000_C3D4,4'd8},         // R8
      {1'b0,1'b0,5'h14,32'h0,1'b0,32'h0,4'd8},                 // R8 dword ptr offset in word
      {1'b0,1'b1,5'h1C,32'h0000_8888,1'b0,32'h0,4'd8},         // R8
      {1'b0,1'b0,5'h16,32'h0,1'b1,32'h0000_C3D4,4'd8},         // R8
      {1'b1,1'b1,5'h14,32'h0000_0028,1'b0,32'h0,4'd2},         // R2 pointer = 40
      {1'b1,1'b1,5'h10,32'h0000_5555,1'b0,32'h0,4'd7},         // R7 write discarded
      {1'b1,1'b0,5'h10,32'h0,1'b1,32'h0,4'd7},                 // R7 reads zero
      {1'b1,1'b1,5'h14,32'h0000_0008,1'b0,32'h0,4'd2},         // pointer = 8
      {1'b1,1'b0,5'h10,32'h0,1'b1,32'h0,4'd7},                 // R7 no alias into CSR8
      {1'b1,1'b1,5'h14,32'h0000_001F,1'b0,32'h0,4'd2},         // pointer = 31
      {1'b1,1'b1,5'h10,32'h0000_6666,1'b0,32'h0,4'd3},         // R3 last entry
      {1'b1,1'b0,5'h10,32'h0,1'b1,32'h0000_6666,4'd3},         // R3
      {1'b1,1'b1,5'h14,32'h0000_0010,1'b0,32'h0,4'd2},         // pointer = 16
      {1'b1,1'b1,5'h1C,32'h0000_9999,1'b0,32'h0,4'd7},         // R7 BCR past end
      {1'b1,1'b0,5'h1C,32'h0,1'b1,32'h0,4'd7},                 // R7
      {1'b1,1'b0,5'h10,32'h0,1'b1,32'h0,4'd3}                  // R3 CSR16 in range
   };

   task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
                  req, act[32], act[31:0], exp[32], exp[31:0]);
      end
   endtask

   // Presents one access at a negedge; the result is sampled one cycle later.
   task automatic access(input logic m, input logic w, input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      dword_mode = m;
      acc_valid  = 1'b1;
      acc_write  = w;
      acc_addr   = a;
      acc_wdata  = d;
      @(negedge clk);
      acc_valid  = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_valid idle", {rd_valid, 32'h0}, {1'b0, 32'h0});
      access(1'b0, 1'b0, 5'h12, 32'h0);
      check("R1 pointer", {rd_valid, rd_data}, {1'b1, 32'h0});
      access(1'b0, 1'b0, 5'h10, 32'h0);
      check("R1 CSR0", {rd_valid, rd_data}, {1'b1, 32'h0});

      for (int i = 0; i < NV; i++) begin
         access(VEC[i][75], VEC[i][74], VEC[i][73:69], VEC[i][68:37]);
         if (VEC[i][36])
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), {rd_valid, rd_data}, VEC[i][36:4]);
         else
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), {rd_valid, 32'h0}, 33'h0);
      end

      // R5: valid lasts one cycle only
      access(1'b0, 1'b0, 5'h10, 32'h0);
      @(negedge clk);
      check("R5 single-cycle valid", {rd_valid, 32'h0}, 33'h0);

      // R8: undecoded word-layout offsets
      access(1'b0, 1'b0, 5'h00, 32'h0);
      check("R8 offset 00h", {rd_valid, 32'h0}, 33'h0);
      access(1'b0, 1'b0, 5'h18, 32'h0);
      check("R8 offset 18h", {rd_valid, 32'h0}, 33'h0);

      // R1: mid-run reset clears pointer and banks
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      access(1'b1, 1'b0, 5'h14, 32'h0);
      check("R1 pointer after reset", {rd_valid, rd_data}, {1'b1, 32'h0});
      access(1'b1, 1'b1, 5'h14, 32'h0000_0005);
      access(1'b1, 1'b0, 5'h10, 32'h0);
      check("R1 CSR5 after reset", {rd_valid, rd_data}, {1'b1, 32'h0});
      access(1'b1, 1'b0, 5'h1C, 32'h0);
      check("R1 BCR5 after reset", {rd_valid, rd_data}, {1'b1, 32'h0});

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule